// File: doc/BRIEF.md
# Posit Result Encoder with Rounding

This block is the last stage of a posit arithmetic datapath. It receives a finished result in unpacked form: a sign, a signed binary scale, a fraction that follows an implied leading one, a sticky bit for everything below that fraction, and two special-case flags. From these it builds the packed posit word. The scale splits into a regime value and an exponent field. The regime becomes a run of identical bits whose length depends on the scale, and the exponent and fraction bits follow for as long as room remains. Everything that does not fit is rounded to nearest, ties to even.

Because the regime length changes with the scale, the point where the word is cut, and so the rounding position, moves with the scale. A round-up may carry out of the fraction into the exponent field and on into the regime. Scales outside the representable range saturate to the largest or smallest positive magnitude. A finite nonzero value never becomes zero or the not-a-real pattern. Negative results are the two's complement of the rounded magnitude. The encoded word can be taken combinationally or through an optional output register that has a clock enable.

Top module: `posit_encoder`

## Requirements
- R1: When `flag_nar` is high the output is the not-a-real pattern, a one in the MSB and zeros elsewhere (0x80 for 8 bits), whatever the other inputs and even when `flag_zero` is also high.
- R2: When `flag_zero` is high and `flag_nar` is low the output is all zeros, whatever the sign.
- R3: For a scale s, the regime value is k = floor(s / 2^ES) and the exponent field is s - k*2^ES. Below the sign bit the magnitude is: for k >= 0, k+1 ones then a zero; for k < 0, -k zeros then a one. Then come the ES exponent bits (MSB first) and then the fraction bits (MSB first), cut off at NBITS-1 bits.
- R4: The bits cut off are rounded to nearest, ties to even. The first discarded bit is the guard. The rest, ORed with `res_sticky`, form the sticky. The magnitude is incremented when guard = 1 and (LSB = 1 or sticky = 1).
- R5: A round-up carry goes through the kept fraction bits into the exponent field and the regime. For example, with 8 bits and ES = 1, scale 0 with fraction 0xF8 encodes as 0x50, and scale 1 with fraction 0xF8 encodes as 0x60.
- R6: If k > NBITS-2 the magnitude saturates to maxpos (all ones below the sign). If k < -(NBITS-2) it saturates to minpos (one in the LSB only). A round-up of maxpos stays at maxpos. A finite nonzero input never encodes to zero or to the not-a-real pattern.
- R7: With `res_sign` = 1 (and no flag set) the output is the two's complement of the rounded, saturated magnitude word, whose sign bit is zero.
- R8: With OUT_REG = 1 the output is registered: it is zero while `rst_n` is low, takes the encoding of the inputs present at a rising clock edge when `en` is high, and holds its value when `en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| en | input | 1 | Clock enable of the output register |
| res_sign | input | 1 | Sign of the result, 1 = negative |
| res_scale | input | SCALE_W | Signed binary scale of the result |
| res_frac | input | FRAC_W | Fraction bits below the implied leading one, MSB first |
| res_sticky | input | 1 | OR of all result bits below `res_frac` |
| flag_zero | input | 1 | Result is exactly zero |
| flag_nar | input | 1 | Result is not-a-real |
| posit_out | output | NBITS | Encoded posit word |

## Verification
The hard cases are those where rounding and the regime boundary fall in the same cycle. A round-up carry goes out of the fraction into the exponent and regime. The same rounding also meets saturation at the edges of the range, where maxpos must not wrap and tiny values must not reach zero. The bench covers these by sweeping every fraction pattern, with both sticky values and both signs, across a scale range wider than the representable one. It compares each word with a bench model that writes the infinite bit string one bit at a time and then rounds that string with integer arithmetic. Directed vectors fix the ripple carries into the exponent and regime, the tie cases, the clamps, flag priority and the output register enable.

// File: rtl/posit_enc_pkg.sv
package posit_enc_pkg;

  // largest regime magnitude that still fits below the sign bit
  function automatic int regime_limit(input int nbits);
    return nbits - 2;
  endfunction

  // not-a-real word of a given width
  function automatic int nar_msb(input int nbits);
    return nbits - 1;
  endfunction

endpackage

// File: rtl/posit_regime_place.sv
module posit_regime_place
  import posit_enc_pkg::*;
#(
  parameter int NBITS   = 8,
  parameter int ES      = 1,
  parameter int FRAC_W  = 8,
  parameter int SCALE_W = 6
) (
  input  logic signed [SCALE_W-1:0] scale,
  input  logic [FRAC_W-1:0]         frac,
  output logic [NBITS-2:0]          mag_cut,
  output logic                      guard_bit,
  output logic                      tail_nz,
  output logic                      too_big,
  output logic                      too_small
);
  localparam int MAGW  = NBITS - 1;
  localparam int BODYW = ES + FRAC_W;
  localparam int VW    = 2 + BODYW + NBITS;
  localparam logic signed [SCALE_W-1:0] KLIM = SCALE_W'(regime_limit(NBITS));

  logic signed [SCALE_W-1:0] k_val;
  logic                      k_neg;
  logic [SCALE_W-1:0]        shamt;
  logic [BODYW-1:0]          body;
  logic [VW-1:0]             pattern;
  logic [VW-1:0]             placed;

  // exponent field is the low ES bits of the scale
  generate
    if (ES > 0) begin : g_exp
      assign body = {scale[ES-1:0], frac};
    end else begin : g_noexp
      assign body = frac;
    end
  endgenerate

  always_comb begin
    k_val     = scale >>> ES;
    k_neg     = k_val[SCALE_W-1];
    too_big   = k_val > KLIM;
    too_small = k_val < -KLIM;
    // extra run length beyond the first bit of the two-bit seed
    shamt     = k_neg ? ~k_val : k_val;
    pattern   = {(k_neg ? 2'b01 : 2'b10), body, {NBITS{1'b0}}};
    if (k_neg)
      placed = pattern >> shamt;
    else
      placed = $signed(pattern) >>> shamt;
    mag_cut   = placed[VW-1 -: MAGW];
    guard_bit = placed[VW-1-MAGW];
    tail_nz   = |placed[VW-2-MAGW:0];
  end
endmodule

// File: rtl/posit_round_rne.sv
module posit_round_rne #(
  parameter int NBITS = 8
) (
  input  logic [NBITS-2:0] mag_cut,
  input  logic             guard_bit,
  input  logic             tail_nz,
  input  logic             sticky_in,
  input  logic             too_big,
  input  logic             too_small,
  output logic [NBITS-2:0] mag_out
);
  localparam int MAGW = NBITS - 1;

  logic          sticky_all;
  logic          bump;
  logic [MAGW:0] sum;

  always_comb begin
    sticky_all = tail_nz | sticky_in;
    bump       = guard_bit & (mag_cut[0] | sticky_all);
    sum        = {1'b0, mag_cut} + {{MAGW{1'b0}}, bump};
    if (too_big)
      mag_out = {MAGW{1'b1}};
    else if (too_small)
      mag_out = {{(MAGW-1){1'b0}}, 1'b1};
    else if (sum[MAGW])
      mag_out = {MAGW{1'b1}};
    else
      mag_out = sum[MAGW-1:0];
  end
endmodule

// File: rtl/posit_sign_pack.sv
module posit_sign_pack
  import posit_enc_pkg::*;
#(
  parameter int NBITS = 8
) (
  input  logic             sign,
  input  logic [NBITS-2:0] mag,
  input  logic             is_zero,
  input  logic             is_nar,
  output logic [NBITS-1:0] word
);
  localparam int TOP = nar_msb(NBITS);

  logic [NBITS-1:0] pos_word;

  always_comb begin
    pos_word = {1'b0, mag};
    if (is_nar) begin
      word      = '0;
      word[TOP] = 1'b1;
    end else if (is_zero)
      word = '0;
    else if (sign)
      word = -pos_word;
    else
      word = pos_word;
  end
endmodule

// File: rtl/posit_encoder.sv
module posit_encoder #(
  parameter int NBITS   = 8,
  parameter int ES      = 1,
  parameter int FRAC_W  = 8,
  parameter int SCALE_W = 6,
  parameter bit OUT_REG = 1'b1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      en,
  input  logic                      res_sign,
  input  logic signed [SCALE_W-1:0] res_scale,
  input  logic [FRAC_W-1:0]         res_frac,
  input  logic                      res_sticky,
  input  logic                      flag_zero,
  input  logic                      flag_nar,
  output logic [NBITS-1:0]          posit_out
);
  logic [NBITS-2:0] mag_cut;
  logic [NBITS-2:0] mag_rnd;
  logic             guard_bit;
  logic             tail_nz;
  logic             too_big;
  logic             too_small;
  logic [NBITS-1:0] word;

  posit_regime_place #(
    .NBITS(NBITS), .ES(ES), .FRAC_W(FRAC_W), .SCALE_W(SCALE_W)
  ) u_place (
    .scale     (res_scale),
    .frac      (res_frac),
    .mag_cut   (mag_cut),
    .guard_bit (guard_bit),
    .tail_nz   (tail_nz),
    .too_big   (too_big),
    .too_small (too_small)
  );

  posit_round_rne #(.NBITS(NBITS)) u_round (
    .mag_cut   (mag_cut),
    .guard_bit (guard_bit),
    .tail_nz   (tail_nz),
    .sticky_in (res_sticky),
    .too_big   (too_big),
    .too_small (too_small),
    .mag_out   (mag_rnd)
  );

  posit_sign_pack #(.NBITS(NBITS)) u_pack (
    .sign    (res_sign),
    .mag     (mag_rnd),
    .is_zero (flag_zero),
    .is_nar  (flag_nar),
    .word    (word)
  );

  generate
    if (OUT_REG) begin : g_reg
      logic [NBITS-1:0] out_q;
      logic [NBITS-1:0] out_d;

      always_comb begin
        out_d = en ? word : out_q;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
      end

      assign posit_out = out_q;
    end else begin : g_comb
      assign posit_out = word;
    end
  endgenerate
endmodule

// File: rtl/posit_encoder_chk.sv
module posit_encoder_chk #(
  parameter int NBITS   = 8,
  parameter bit OUT_REG = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             res_sign,
  input logic             flag_zero,
  input logic             flag_nar,
  input logic [NBITS-1:0] posit_out
);
  localparam logic [NBITS-1:0] NAR_W = {1'b1, {(NBITS-1){1'b0}}};

  generate
    if (OUT_REG) begin : g_seq
      assert_nar_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (en && flag_nar) |=> (posit_out == NAR_W));
      assert_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && flag_zero && !flag_nar) |=> (posit_out == '0));
      assert_never_lost_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !flag_zero && !flag_nar) |=> (posit_out != '0 && posit_out != NAR_W));
      assert_sign_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !flag_zero && !flag_nar) |=> (posit_out[NBITS-1] == $past(res_sign)));
      assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(posit_out));
    end else begin : g_cmb
      always_comb begin
        if (flag_nar)
          assert_nar_R1: assert (posit_out == NAR_W);
        else if (flag_zero)
          assert_zero_R2: assert (posit_out == '0);
        else begin
          assert_never_lost_R6: assert (posit_out != '0 && posit_out != NAR_W);
          assert_sign_R7: assert (posit_out[NBITS-1] == res_sign);
        end
      end
    end
  endgenerate
endmodule

bind posit_encoder posit_encoder_chk #(.NBITS(NBITS), .OUT_REG(OUT_REG)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .en        (en),
  .res_sign  (res_sign),
  .flag_zero (flag_zero),
  .flag_nar  (flag_nar),
  .posit_out (posit_out)
);

// File: tb/posit_encoder_test.sv
module posit_encoder_test;
  localparam int N  = 8;
  localparam int ES = 1;
  localparam int FW = 8;
  localparam int SW = 6;
  localparam int MAXMAG = (1 << (N-1)) - 1;

  logic                 clk = 1'b0;
  logic                 rst_n;
  logic                 en;
  logic                 res_sign;
  logic signed [SW-1:0] res_scale;
  logic [FW-1:0]        res_frac;
  logic                 res_sticky;
  logic                 flag_zero;
  logic                 flag_nar;
  logic [N-1:0]         posit_out;

  int n_cmp  = 0;
  int n_bad  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  posit_encoder #(.NBITS(N), .ES(ES), .FRAC_W(FW), .SCALE_W(SW), .OUT_REG(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .en(en), .res_sign(res_sign), .res_scale(res_scale),
    .res_frac(res_frac), .res_sticky(res_sticky), .flag_zero(flag_zero),
    .flag_nar(flag_nar), .posit_out(posit_out)
  );

  // bit-serial reference: write the unbounded string, then round it as an integer
  function automatic logic [N-1:0] model(input bit s, input int sc, input int fr,
                                         input bit stk, input bit z, input bit nr);
    int k, e, mag, n, gd, st;
    bit bits[32];
    if (nr) return 8'h80;
    if (z)  return 8'h00;
    k = sc >>> ES;
    e = sc - (k << ES);
    if (k > N-2) mag = MAXMAG;
    else if (k < -(N-2)) mag = 1;
    else begin
      n = 0;
      for (int i = 0; i < 32; i++) bits[i] = 1'b0;
      if (k >= 0) begin
        for (int i = 0; i <= k; i++) begin bits[n] = 1'b1; n++; end
        bits[n] = 1'b0; n++;
      end else begin
        for (int i = 0; i < -k; i++) begin bits[n] = 1'b0; n++; end
        bits[n] = 1'b1; n++;
      end
      for (int i = ES-1; i >= 0; i--) begin bits[n] = e[i]; n++; end
      for (int i = FW-1; i >= 0; i--) begin bits[n] = fr[i]; n++; end
      mag = 0;
      for (int i = 0; i < N-1; i++) mag = mag * 2 + int'(bits[i]);
      gd = int'(bits[N-1]);
      st = int'(stk);
      for (int i = N; i < 32; i++) st = st | int'(bits[i]);
      if (gd != 0 && ((mag & 1) != 0 || st != 0)) mag++;
      if (mag > MAXMAG) mag = MAXMAG;
    end
    return s ? N'((256 - mag) & 255) : N'(mag);
  endfunction

  task automatic check(input string req, input logic [N-1:0] exp_v);
    n_cmp++;
    if (posit_out !== exp_v) begin
      n_bad++;
      $display("FAIL %s: sign=%0d scale=%0d frac=%02h stk=%0d z=%0d nar=%0d got=%02h expected=%02h",
               req, res_sign, res_scale, res_frac, res_sticky, flag_zero, flag_nar,
               posit_out, exp_v);
    end
  endtask

  // drive at a falling edge, capture at the rising edge, sample at the next falling edge
  task automatic apply(input string req, input bit s, input int sc, input int fr,
                       input bit stk, input bit z, input bit nr);
    res_sign   = s;
    res_scale  = SW'(sc);
    res_frac   = FW'(fr);
    res_sticky = stk;
    flag_zero  = z;
    flag_nar   = nr;
    @(posedge clk);
    @(negedge clk);
    check(req, model(s, sc, fr, stk, z, nr));
  endtask

  function automatic string sweep_tag(input bit s, input int sc);
    int k;
    k = sc >>> ES;
    if (k > N-2 || k < -(N-2)) return "R6";
    if (s) return "R7";
    return "R3 R4";
  endfunction

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; en = 1'b1;
    res_sign = 1'b0; res_scale = '0; res_frac = 8'hFF; res_sticky = 1'b1;
    flag_zero = 1'b0; flag_nar = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 reset", 8'h00);
    rst_n = 1'b1;

    // R3 regime, exponent and fraction placement
    apply("R3", 0, 0, 8'h00, 0, 0, 0);
    apply("R3", 0, 2, 8'h00, 0, 0, 0);
    apply("R3", 0, -1, 8'h00, 0, 0, 0);
    apply("R3", 0, -12, 8'h00, 0, 0, 0);
    apply("R3", 0, 12, 8'h00, 0, 0, 0);
    apply("R3", 0, 0, 8'hA0, 0, 0, 0);
    // R4 ties to even, sticky breaks the tie
    apply("R4 tie-even-down", 0, 0, 8'h08, 0, 0, 0);
    apply("R4 tie-odd-up", 0, 0, 8'h18, 0, 0, 0);
    apply("R4 sticky-up", 0, 0, 8'h08, 1, 0, 0);
    apply("R4 below-half", 0, 0, 8'h07, 1, 0, 0);
    // R5 carry into exponent and into regime
    apply("R5 into-exponent", 0, 0, 8'hF8, 0, 0, 0);
    apply("R5 into-regime", 0, 1, 8'hF8, 0, 0, 0);
    // R6 clamps
    apply("R6 over", 0, 14, 8'hFF, 1, 0, 0);
    apply("R6 under", 0, -13, 8'h00, 0, 0, 0);
    apply("R6 over-neg", 1, 20, 8'h55, 0, 0, 0);
    apply("R6 under-neg", 1, -20, 8'h55, 1, 0, 0);
    // R7 negation
    apply("R7", 1, 0, 8'h00, 0, 0, 0);
    apply("R7", 1, 3, 8'h81, 1, 0, 0);
    // R1 and R2 flags
    apply("R1", 1, 5, 8'h3C, 1, 0, 1);
    apply("R1 over-zero", 0, -3, 8'h00, 0, 1, 1);
    apply("R2", 1, 7, 8'hC3, 1, 1, 0);

    // R8 enable low holds the previous word
    apply("R8 load", 0, 0, 8'h00, 0, 0, 0);
    en = 1'b0;
    res_sign = 1'b1; res_scale = SW'(9); flag_nar = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R8 hold", 8'h40);
    en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R8 reload", 8'h80);

    // sweep: every fraction, both stickies, both signs, scales past both clamps
    for (int sc = -20; sc <= 20; sc++)
      for (int fr = 0; fr < 256; fr++)
        for (int s = 0; s < 2; s++)
          for (int st = 0; st < 2; st++)
            apply(sweep_tag(bit'(s), sc), bit'(s), sc, fr, bit'(st), 0, 0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule